// File: doc/BRIEF.md
# Repeating Memory Byte Search Engine

This block scans memory for a byte equal to an 8-bit reference value. A start pulse loads a search code, the reference value, a 16-bit address pointer, a 16-bit iteration counter and the incoming status flags. The engine then repeats one iteration after another. Each iteration reads the byte the pointer addresses and subtracts it from the reference value. The difference only sets flags and is then thrown away. The pointer then steps forward or backward, and the counter steps down by one.

The search stops on the first byte that equals the reference value, or when the counter reaches zero, whichever comes first. When it stops, the engine returns the stepped pointer and counter and the updated flag byte, and pulses `done_o`. The cycle timing of each iteration follows a fixed machine-cycle pattern, so a surrounding sequencer can stay cycle-exact with this block.

Top module: `mem_search_engine`

## Requirements
- R1: When `start_i` is high in a cycle where `busy_o` is low, the engine latches `op_i`, `acc_i`, `ptr_i`, `cnt_i` and `flags_i`, and `busy_o` is high in the next cycle. A `start_i` pulse seen while `busy_o` is high is ignored and leaves the result unchanged.
- R2: Bit 3 of `op_i` selects the direction. When it is 0 (code 0xB1) the pointer rises by 1 per iteration. When it is 1 (code 0xB9) the pointer falls by 1. The pointer wraps modulo 65536.
- R3: The counter falls by 1 on every iteration and wraps modulo 65536. A start count of 0 therefore allows 65536 iterations.
- R4: The search stops after the first iteration whose byte equals `acc_i`, or after the iteration that leaves the counter at zero. A matching iteration still steps the pointer and the counter.
- R5: In `flags_o`, bit 6 (zero) is set when the byte equals the reference value and cleared otherwise. Bit 7 (sign) equals bit 7 of the reference value minus the byte, taken modulo 256.
- R6: In `flags_o`, bit 4 (half-carry) is set when the low nibble of the reference value is less than the low nibble of the byte, which is a borrow out of bit 4. Bit 1 (subtract) is set. Bits 5, 3 and 0 keep the values latched from `flags_i`.
- R7: In `flags_o`, bit 2 (parity/overflow) is set when the decremented counter is non-zero and cleared when it is zero.
- R8: An iteration that is followed by another iteration lasts 21 clocks (4+4+3+5+5). The final iteration lasts 16 clocks (4+4+3+5). So `busy_o` stays high for 21·(n−1)+16 cycles for n iterations. `done_o` is high for exactly one cycle, in the first cycle with `busy_o` low.
- R9: `mem_rd_o` is high for clocks 9 to 11 of each iteration, 3 clocks in all, with `mem_addr_o` equal to the current pointer. The byte is taken from `mem_data_i` in the last of those clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| op_i | input | 8 | Search code; bit 3 selects decrement |
| acc_i | input | 8 | Reference value |
| ptr_i | input | 16 | Start address |
| cnt_i | input | 16 | Start count (0 means 65536) |
| flags_i | input | 8 | Incoming flag byte |
| mem_addr_o | output | 16 | Memory read address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_data_i | input | 8 | Memory read data |
| ptr_o | output | 16 | Updated pointer |
| cnt_o | output | 16 | Updated counter |
| flags_o | output | 8 | Updated flag byte |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps all 256 reference values over a fixed six-byte window in both directions. Most values never match, so those runs end on the count; the few values that do match end early at a known position. This separates the two stop causes, and it exercises the sign and half-borrow flags across every operand pair the window holds. Directed runs cover the corners. One pointer wraps through 0xFFFF, one search starts with a count of zero, one single-iteration search does not match, one search matches on its first byte, and one run sends a start pulse in the middle of an operation. Every run is also checked for its busy length, its read-strobe count and the address of each read.

// File: rtl/mse_pkg.sv
package mse_pkg;
    // flag byte bit positions
    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_H  = 4;
    localparam int FL_PV = 2;
    localparam int FL_N  = 1;
    // search code bit choosing the downward direction
    localparam int DIR_BIT = 3;
    // default clocks per machine cycle of one iteration
    localparam int PH_FETCH1 = 4;
    localparam int PH_FETCH2 = 4;
    localparam int PH_READ   = 3;
    localparam int PH_CALC   = 5;
    localparam int PH_REPEAT = 5;
endpackage

// File: rtl/mse_phase.sv
module mse_phase #(
    parameter int T_M1 = mse_pkg::PH_FETCH1,
    parameter int T_M2 = mse_pkg::PH_FETCH2,
    parameter int T_RD = mse_pkg::PH_READ,
    parameter int T_M4 = mse_pkg::PH_CALC,
    parameter int T_M5 = mse_pkg::PH_REPEAT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic rd_o,
    output logic cap_o,
    output logic eval_o
);
    localparam int RD_FIRST  = T_M1 + T_M2;
    localparam int RD_LAST   = RD_FIRST + T_RD - 1;
    localparam int END_SHORT = RD_LAST + T_M4;
    localparam int END_LONG  = END_SHORT + T_M5;
    localparam int TICK_W    = $clog2(END_LONG + 1);

    logic [TICK_W-1:0] tick_d, tick_q;

    always_comb begin
        tick_d = tick_q;
        if (clear_i) begin
            tick_d = '0;
        end else if (run_i) begin
            if (tick_q == TICK_W'(END_LONG)) tick_d = '0;
            else                             tick_d = tick_q + TICK_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    assign rd_o   = run_i && (tick_q >= TICK_W'(RD_FIRST)) && (tick_q <= TICK_W'(RD_LAST));
    assign cap_o  = run_i && (tick_q == TICK_W'(RD_LAST));
    assign eval_o = run_i && (tick_q == TICK_W'(END_SHORT));

    assert_tick_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q <= TICK_W'(END_LONG));
    assert_eval_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |=> !eval_o);
endmodule

// File: rtl/mse_cmp_unit.sv
module mse_cmp_unit #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              dec_i,
    input  logic [7:0]        flags_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [7:0]        flags_o,
    output logic              stop_o
);
    import mse_pkg::*;
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] diff;
    logic [HALF_W:0]   half_diff;
    logic              equal;

    always_comb begin
        diff      = acc_i - data_i;
        half_diff = {1'b0, acc_i[HALF_W-1:0]} - {1'b0, data_i[HALF_W-1:0]};
        equal     = (acc_i == data_i);
        ptr_o     = dec_i ? ptr_i - ADDR_W'(1) : ptr_i + ADDR_W'(1);
        cnt_o     = cnt_i - CNT_W'(1);
        flags_o         = flags_i;
        flags_o[FL_S]   = diff[DATA_W-1];
        flags_o[FL_Z]   = equal;
        flags_o[FL_H]   = half_diff[HALF_W];
        flags_o[FL_PV]  = |cnt_o;
        flags_o[FL_N]   = 1'b1;
        stop_o          = equal || (cnt_o == '0);
    end
endmodule

// File: rtl/mem_search_engine.sv
module mem_search_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [7:0]        flags_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [7:0]        flags_o,
    output logic              busy_o,
    output logic              done_o
);
    import mse_pkg::*;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              dec;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        flags;
    } eng_state_t;

    eng_state_t s_d, s_q;

    logic              accept;
    logic              rd_win, cap, eval;
    logic [ADDR_W-1:0] ptr_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic [7:0]        flags_nx;
    logic              stop;

    assign accept = start_i && !s_q.busy;

    mse_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .run_i   (s_q.busy),
        .rd_o    (rd_win),
        .cap_o   (cap),
        .eval_o  (eval)
    );

    mse_cmp_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
        .acc_i   (s_q.acc),
        .data_i  (s_q.data),
        .ptr_i   (s_q.ptr),
        .cnt_i   (s_q.cnt),
        .dec_i   (s_q.dec),
        .flags_i (s_q.flags),
        .ptr_o   (ptr_nx),
        .cnt_o   (cnt_nx),
        .flags_o (flags_nx),
        .stop_o  (stop)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.dec   = op_i[DIR_BIT];
            s_d.acc   = acc_i;
            s_d.ptr   = ptr_i;
            s_d.cnt   = cnt_i;
            s_d.flags = flags_i;
        end else if (s_q.busy) begin
            if (cap) s_d.data = mem_data_i;
            if (eval) begin
                s_d.ptr   = ptr_nx;
                s_d.cnt   = cnt_nx;
                s_d.flags = flags_nx;
                if (stop) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_addr_o = s_q.ptr;
    assign mem_rd_o   = rd_win;
    assign ptr_o      = s_q.ptr;
    assign cnt_o      = s_q.cnt;
    assign flags_o    = s_q.flags;
    assign busy_o     = s_q.busy;
    assign done_o     = s_q.done;

    assert_read_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o ##1 !done_o);
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && eval) |=> cnt_o == $past(cnt_o) - CNT_W'(1));
    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && eval) |=> (ptr_o == ($past(s_q.dec) ? $past(ptr_o) - ADDR_W'(1)
                                                        : $past(ptr_o) + ADDR_W'(1))));
    assert_stop_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flags_o[FL_Z] || cnt_o == '0));
    assert_pv_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flags_o[FL_PV] == (cnt_o != '0)));
    assert_sub_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flags_o[FL_N]);
    assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(s_q.acc) && $stable(s_q.dec));
endmodule

// File: tb/tb_mem_search_engine.sv
`timescale 1ns/1ps
module tb_mem_search_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  op_i = 8'h00;
    logic [7:0]  acc_i = 8'h00;
    logic [15:0] ptr_i = 16'h0000;
    logic [15:0] cnt_i = 16'h0000;
    logic [7:0]  flags_i = 8'h00;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o;
    logic [7:0]  mem_data_i;
    logic [15:0] ptr_o, cnt_o;
    logic [7:0]  flags_o;
    logic        busy_o, done_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fmem(input logic [15:0] a);
        return a[7:0] * 8'd13 + a[15:8];
    endfunction

    assign mem_data_i = fmem(mem_addr_o);

    mem_search_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .acc_i(acc_i),
        .ptr_i(ptr_i), .cnt_i(cnt_i), .flags_i(flags_i), .mem_addr_o(mem_addr_o),
        .mem_rd_o(mem_rd_o), .mem_data_i(mem_data_i), .ptr_o(ptr_o), .cnt_o(cnt_o),
        .flags_o(flags_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] op, input logic [7:0] acc, input logic [15:0] ptr,
                       input logic [15:0] cnt, input logic [7:0] fl, input bit poke);
        logic [15:0] p = ptr;
        logic [15:0] c = cnt;
        logic [7:0]  f = fl;
        logic [7:0]  b, d;
        int n = 0;
        bit stop = 0;
        int cyc = 0, rds = 0, addr_bad = 0;
        while (!stop) begin
            b = fmem(p);
            d = acc - b;
            p = op[3] ? p - 16'd1 : p + 16'd1;
            c = c - 16'd1;
            n++;
            f[7] = d[7];
            f[6] = (acc == b);
            f[4] = (acc[3:0] < b[3:0]);
            f[2] = (c != 16'd0);
            f[1] = 1'b1;
            stop = (acc == b) || (c == 16'd0);
        end
        @(negedge clk);
        start_i = 1'b1; op_i = op; acc_i = acc; ptr_i = ptr; cnt_i = cnt; flags_i = fl;
        @(negedge clk);
        start_i = 1'b0;
        check("R1 busy after start", busy_o, 1'b1);
        while (!done_o) begin
            if (busy_o) cyc++;
            if (mem_rd_o) begin
                logic [15:0] ea = op[3] ? ptr - 16'(rds / 3) : ptr + 16'(rds / 3);
                if (mem_addr_o !== ea) addr_bad++;
                rds++;
            end
            if (poke && cyc == 5) begin
                start_i = 1'b1; op_i = op ^ 8'h08; acc_i = ~acc; ptr_i = ~ptr; cnt_i = 16'd1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        check("R8 busy low at done", busy_o, 1'b0);
        check("R2 R4 pointer", ptr_o, p);
        check("R3 R4 counter", cnt_o, c);
        check("R5 R6 R7 flags", flags_o, f);
        check("R8 busy cycles", cyc, 21 * (n - 1) + 16);
        check("R9 read cycles", rds, 3 * n);
        check("R9 read addresses", addr_bad, 0);
        @(negedge clk);
        check("R8 done one cycle", done_o, 1'b0);
    endtask

    initial begin
        #950000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy", busy_o, 1'b0);
        check("R8 reset done", done_o, 1'b0);
        check("R9 reset read", mem_rd_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // sweep of all reference values, both directions
        for (int a = 0; a < 256; a++) run(8'hB1, 8'(a), 16'h3404, 16'd6, 8'h29, 0);
        for (int a = 0; a < 256; a++) run(8'hB9, 8'(a), 16'h0002, 16'd6, 8'h00, 0);
        // pointer wrap upward, no match expected within window
        run(8'hB1, 8'hEE, 16'hFFFE, 16'd5, 8'hFF, 0);
        // start count zero: match after a few iterations (R3 wrap)
        run(8'hB1, fmem(16'h1203), 16'h1200, 16'd0, 8'h01, 0);
        // single iteration, no match
        run(8'hB9, fmem(16'h4000) + 8'd1, 16'h4000, 16'd1, 8'h28, 0);
        // match on first byte
        run(8'hB9, fmem(16'h5555), 16'h5555, 16'd9, 8'h00, 0);
        // R1: start while busy is ignored
        run(8'hB1, 8'h77, 16'h2000, 16'd4, 8'h08, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule